// File: doc/BRIEF.md
# Multiply-Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division beside a processor's main datapath. A command carries an operation code and two operands. Multiply and divide commands run for a fixed number of cycles. Their results land in a private pair of result registers called HI and LO. Software copies either register back to a general register through a read port. The processor can also load HI or LO directly from an operand.

Multiplication uses a radix-2 shift-and-add loop. Division uses a restoring loop. Both loops work on operand magnitudes and apply the signs in a final cycle. A busy output covers the whole computation. Reads that arrive while busy is high are held off, and commands that arrive while busy is high are dropped.

Top module: `mdu_hilo`

## Requirements
- R1: After reset, busy is low and both HI and LO read as zero.
- R2: Unsigned multiply (cmdOp 1) sets HI to the upper 32 bits and LO to the lower 32 bits of the 64-bit unsigned product.
- R3: Signed multiply (cmdOp 0) sets HI and LO to the upper and lower halves of the 64-bit two's-complement product.
- R4: Unsigned divide (cmdOp 3) places the quotient in LO and the remainder in HI. In cmdOp 3 and cmdOp 2 (R5), opA is the dividend and opB is the divisor.
- R5: Signed divide (cmdOp 2) truncates the quotient toward zero and gives the remainder the dividend's sign. The case 0x80000000 divided by -1 gives LO = 0x80000000 and HI = 0.
- R6: A divide with opB = 0 completes normally and leaves HI equal to opA. LO becomes 0xFFFFFFFF, except for a signed divide with a negative opA, where LO becomes 1.
- R7: For an accepted multiply or divide, busy goes high in the cycle after acceptance and stays high for exactly 33 cycles. The new HI and LO are readable in the first cycle with busy low.
- R8: A command presented while busy is high has no effect on busy timing, HI or LO.
- R9: cmdOp 4 copies opA into HI and cmdOp 5 copies opA into LO, visible in the next cycle, without raising busy. cmdOp 6 and 7 are ignored.
- R10: rdData shows HI when rdSel is 1 and LO when rdSel is 0. rdValid equals rdReq while busy is low and is held low while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Operation code (see R2 to R9) |
| opA | input | 32 | First operand: multiplicand, dividend, or write data |
| opB | input | 32 | Second operand: multiplier or divisor |
| busy | output | 1 | Computation in progress |
| rdReq | input | 1 | Request to read HI or LO |
| rdSel | input | 1 | Read select: 1 = HI, 0 = LO |
| rdValid | output | 1 | rdData holds the requested register this cycle |
| rdData | output | 32 | Contents of the selected result register |

## Verification
The assertions rely on the command and read inputs being stable across each rising edge. They also rely on cmdOp holding a defined code whenever cmdValid is high. The stimulus meets this by changing all inputs only on falling edges and by always driving known values. It covers sign combinations, the most negative operand, zero divisors, and commands and reads issued while busy is high. A behavioural model built on 64-bit integer arithmetic predicts busy, rdValid and rdData, and the bench compares them on every cycle.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_MULS = 3'd0,
    OP_MULU = 3'd1,
    OP_DIVS = 3'd2,
    OP_DIVU = 3'd3,
    OP_WRHI = 3'd4,
    OP_WRLO = 3'd5
  } mdu_op_e;

  typedef struct packed {
    logic load;
    logic step;
    logic fin;
    logic wrHi;
    logic wrLo;
  } mdu_strobe_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  output logic        busy,
  output mdu_strobe_t strb
);
  localparam int CW = $clog2(W);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} state_e;

  state_e        state;
  logic [CW-1:0] iterCnt;

  always_comb begin
    strb = '0;
    unique case (state)
      S_IDLE: begin
        if (cmdValid) begin
          case (cmdOp)
            OP_MULS, OP_MULU, OP_DIVS, OP_DIVU: strb.load = 1'b1;
            OP_WRHI:                            strb.wrHi = 1'b1;
            OP_WRLO:                            strb.wrLo = 1'b1;
            default: ;
          endcase
        end
      end
      S_RUN:   strb.step = 1'b1;
      S_FIX:   strb.fin  = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      iterCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (strb.load) begin
          state   <= S_RUN;
          iterCnt <= '0;
        end
        S_RUN: begin
          if (iterCnt == CW'(W - 1)) state <= S_FIX;
          iterCnt <= iterCnt + 1'b1;
        end
        S_FIX:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/mdu_dp.sv
module mdu_dp
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdu_strobe_t  strb,
  input  logic [2:0]   cmdOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut
);
  localparam int DW = 2 * W;

  logic [W-1:0] hiReg, loReg;
  logic [W-1:0] hiW, loW, mReg;
  logic         isDiv, negQ, negR;

  logic         inDiv, inSgn;
  logic [W-1:0] magA, magB;

  always_comb begin
    inDiv = (cmdOp == OP_DIVS) || (cmdOp == OP_DIVU);
    inSgn = (cmdOp == OP_DIVS) || (cmdOp == OP_MULS);
    magA  = (inSgn && opA[W-1]) ? -opA : opA;
    magB  = (inSgn && opB[W-1]) ? -opB : opB;
  end

  // one iteration of each loop
  logic [W:0]    mulSum;
  logic [W:0]    divShift;
  logic [W+1:0]  divDiff;
  logic          divOk;
  logic [DW-1:0] fullProd, signedProd;

  always_comb begin
    mulSum     = {1'b0, hiW} + (loW[0] ? {1'b0, mReg} : '0);
    divShift   = {hiW, loW[W-1]};
    divDiff    = {1'b0, divShift} - {2'b0, mReg};
    divOk      = ~divDiff[W+1];
    fullProd   = {hiW, loW};
    signedProd = negQ ? -fullProd : fullProd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg <= '0; loReg <= '0;
      hiW   <= '0; loW   <= '0; mReg <= '0;
      isDiv <= 1'b0; negQ <= 1'b0; negR <= 1'b0;
    end else begin
      if (strb.load) begin
        isDiv <= inDiv;
        negQ  <= inSgn && (opA[W-1] ^ opB[W-1]);
        negR  <= inSgn && inDiv && opA[W-1];
        hiW   <= '0;
        mReg  <= inDiv ? magB : magA;
        loW   <= inDiv ? magA : magB;
      end
      if (strb.step) begin
        if (isDiv) begin
          hiW <= divOk ? divDiff[W-1:0] : divShift[W-1:0];
          loW <= {loW[W-2:0], divOk};
        end else begin
          {hiW, loW} <= {mulSum, loW[W-1:1]};
        end
      end
      if (strb.fin) begin
        if (isDiv) begin
          loReg <= negQ ? -loW : loW;
          hiReg <= negR ? -hiW : hiW;
        end else begin
          hiReg <= signedProd[DW-1:W];
          loReg <= signedProd[W-1:0];
        end
      end
      if (strb.wrHi) hiReg <= opA;
      if (strb.wrLo) loReg <= opA;
    end
  end

  assign hiOut = hiReg;
  assign loOut = loReg;

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic [2:0]   cmdOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  input  logic         rdReq,
  input  logic         rdSel,
  output logic         rdValid,
  output logic [W-1:0] rdData
);
  mdu_strobe_t  strb;
  logic [W-1:0] hiVal, loVal;

  mdu_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .busy(busy), .strb(strb)
  );

  mdu_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdOp(cmdOp),
    .opA(opA), .opB(opB), .hiOut(hiVal), .loOut(loVal)
  );

  assign rdValid = rdReq && !busy;
  assign rdData  = rdSel ? hiVal : loVal;

endmodule

// File: rtl/mdu_hilo_chk.sv
module mdu_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         cmdValid,
  input logic [2:0]   cmdOp,
  input logic [W-1:0] opA,
  input logic         busy,
  input logic         rdReq,
  input logic         rdSel,
  input logic         rdValid,
  input logic [W-1:0] rdData
);
  localparam int LW = $clog2(W + 2) + 1;

  logic [LW-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else       runLen <= busy ? runLen + 1'b1 : '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rstN |=> !busy);

  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && cmdOp < 3'd4) |=> busy);

  // R7 and R8: a command during busy must not stretch the run
  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> runLen == LW'(W + 1));

  p_busy_cap_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> runLen <= LW'(W + 1));

  p_write_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && (cmdOp == 3'd4 || cmdOp == 3'd5)) |=> !busy);

  p_write_hi_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && cmdOp == 3'd4) ##1 rdSel |-> rdData == $past(opA));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !rdValid);

  p_read_ok_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !busy) |-> rdValid);

endmodule

bind mdu_hilo mdu_hilo_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .opA(opA),
  .busy(busy), .rdReq(rdReq), .rdSel(rdSel), .rdValid(rdValid), .rdData(rdData)
);

// File: tb/mdu_hilo_test.sv
`timescale 1ns/1ps
module mdu_hilo_test;
  localparam int W = 32;
  localparam int RUN = W + 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdValid = 1'b0;
  logic [2:0]   cmdOp = 3'd0;
  logic [W-1:0] opA = '0, opB = '0;
  logic         busy, rdValid;
  logic         rdReq = 1'b0, rdSel = 1'b0;
  logic [W-1:0] rdData;

  always #10 clk = ~clk;

  mdu_hilo #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .opA(opA), .opB(opB), .busy(busy), .rdReq(rdReq), .rdSel(rdSel),
    .rdValid(rdValid), .rdData(rdData)
  );

  int totalCnt = 0, failCnt = 0, cyc = 0;
  bit done = 0;
  string curTag = "R1";

  // behavioural reference
  logic [31:0] mHi = '0, mLo = '0, pHi = '0, pLo = '0;
  int mCnt = 0;

  task automatic calc(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                      output logic [31:0] hi, output logic [31:0] lo);
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    hi = '0; lo = '0;
    case (op)
      3'd0: begin p = 64'(sa * sb); hi = p[63:32]; lo = p[31:0]; end
      3'd1: begin p = {32'd0, a} * {32'd0, b}; hi = p[63:32]; lo = p[31:0]; end
      3'd2: begin
        if (b == 0) begin hi = a; lo = a[31] ? 32'd1 : 32'hFFFF_FFFF; end
        else begin q = sa / sb; r = sa % sb; lo = q[31:0]; hi = r[31:0]; end
      end
      3'd3: begin
        if (b == 0) begin hi = a; lo = 32'hFFFF_FFFF; end
        else begin lo = a / b; hi = a % b; end
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mHi = '0; mLo = '0; mCnt = 0;
    end else if (mCnt > 0) begin
      mCnt = mCnt - 1;
      if (mCnt == 0) begin mHi = pHi; mLo = pLo; end
    end else if (cmdValid) begin
      if (cmdOp < 3'd4) begin
        calc(cmdOp, opA, opB, pHi, pLo);
        mCnt = RUN;
      end else if (cmdOp == 3'd4) mHi = opA;
      else if (cmdOp == 3'd5) mLo = opA;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rstN && !done) begin
      check("R7 busy", 32'(busy), 32'(mCnt != 0));
      check("R10 rdValid", 32'(rdValid), 32'(rdReq && mCnt == 0));
      if (rdReq && mCnt == 0)
        check({curTag, " rdData"}, rdData, rdSel ? mHi : mLo);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      totalCnt++; failCnt++;
      $display("FAIL watchdog actual=%0d expected<20000 cycles", cyc);
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  task automatic readBoth();
    rdReq = 1'b1; rdSel = 1'b0;
    @(negedge clk); rdSel = 1'b1;
    @(negedge clk); rdSel = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    cmdValid = 1'b1; cmdOp = op; opA = a; opB = b;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic run(input string tag, input logic [2:0] op,
                     input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    curTag = tag; rdReq = 1'b1;
    issue(op, a, b);
    repeat (RUN + 2) @(negedge clk);
    readBoth();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curTag = "R1";
    readBoth();

    run("R2", 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run("R2", 3'd1, 32'h1234_5678, 32'h9ABC_DEF0);
    run("R3", 3'd0, -32'sd3, 32'd7);
    run("R3", 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run("R3", 3'd0, 32'h8000_0000, 32'h8000_0000);
    run("R3", 3'd0, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    run("R4", 3'd3, 32'd100, 32'd7);
    run("R4", 3'd3, 32'hFFFF_FFFF, 32'd3);
    run("R4", 3'd3, 32'd5, 32'd10);
    run("R5", 3'd2, -32'sd7, 32'd2);
    run("R5", 3'd2, 32'd7, -32'sd2);
    run("R5", 3'd2, -32'sd7, -32'sd2);
    run("R5", 3'd2, 32'h8000_0000, 32'hFFFF_FFFF);
    run("R6", 3'd3, 32'd1234, 32'd0);
    run("R6", 3'd2, -32'sd5, 32'd0);
    run("R6", 3'd2, 32'h8000_0000, 32'd0);

    // R9: direct writes, and unused codes ignored
    @(negedge clk); curTag = "R9";
    issue(3'd4, 32'hCAFE_0001, 32'd0);
    readBoth();
    issue(3'd5, 32'hBEEF_0002, 32'd0);
    readBoth();
    issue(3'd6, 32'h1111_1111, 32'd0);
    issue(3'd7, 32'h2222_2222, 32'd0);
    readBoth();

    // R8: commands during busy are dropped
    curTag = "R8";
    issue(3'd3, 32'd1000, 32'd3);
    repeat (4) @(negedge clk);
    issue(3'd1, 32'd5, 32'd5);
    issue(3'd4, 32'hDEAD_DEAD, 32'd0);
    repeat (10) @(negedge clk);
    issue(3'd5, 32'h5555_5555, 32'd0);
    repeat (RUN) @(negedge clk);
    readBoth();

    done = 1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule